// File: doc/BRIEF.md
# Frame Waiting Time Supervisor

This block is the reader-side timer that watches how long a proximity card takes to begin its reply. It counts carrier-clock cycles from the moment the reader finishes sending a frame. If the card has not started answering when the armed limit is reached, the block raises a single-cycle timeout, and the reader may then transmit again. When the card starts a reply, the block stops counting.

The limit comes from a 4-bit waiting-time exponent. In the activation and deactivation phases the limit is fixed instead. A card may ask for more time with a 6-bit multiplier. Once the reader accepts that request, the next wait it arms is the base limit times the multiplier, capped at the largest legal waiting time. The extension lasts until the next card block is received. Multiplier codes outside the legal range are refused and flagged. Retry policy and the forming of frames belong to the surrounding reader logic.

Top module: `fwt_supervisor`

## Requirements
- R1: In normal mode with no extension pending, a pulse on `tx_end_i` arms `limit_o` = 2^BASE_SHIFT × 2^fwi. Any fwi above MAX_EXP (including the reserved code 15) is treated as MAX_EXP. `limit_o` changes only on a `tx_end_i` pulse.
- R2: While `act_mode_i` is high, a `tx_end_i` pulse arms the fixed limit 2^(BASE_SHIFT+ACT_EXP), whatever the exponent or extension state. A held extension is kept for later normal-mode waits.
- R3: If `tx_end_i` is sampled at clock edge E0 and no `rx_start_i` follows, `timeout_o` is high for exactly one cycle, directly after edge E0+L, where L is the armed limit.
- R4: A `rx_start_i` sampled at any edge from E0+1 up to and including E0+L cancels the wait, and no timeout follows.
- R5: A `wtx_load_i` pulse with a multiplier m in 1..59 makes the next normal-mode arm use min(base × m, 2^(BASE_SHIFT+MAX_EXP)).
- R6: An accepted extension stays in force across timeouts and re-arms. It ends only when `rx_start_i` is sampled, and later arms fall back to the base limit.
- R7: A `wtx_load_i` pulse with m = 0 or m in 60..63 leaves the extension state unchanged. It drives `wtxm_err_o` high for exactly the cycle after that pulse. A legal load leaves `wtxm_err_o` low.
- R8: A `tx_end_i` pulse during a running wait restarts the count from zero with a freshly selected limit.
- R9: After reset, `timeout_o` and `wtxm_err_o` are low and `limit_o` shows the activation limit. No timeout occurs until a `tx_end_i` pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier-derived clock, one cycle per carrier period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwi_i | input | FWI_W | Waiting-time exponent |
| act_mode_i | input | 1 | High during activation or deactivation |
| tx_end_i | input | 1 | Pulse: reader finished transmitting |
| rx_start_i | input | 1 | Pulse: card reply has started |
| wtx_load_i | input | 1 | Pulse: reader accepted an extension request |
| wtxm_i | input | WTXM_W | Extension multiplier from the card request |
| timeout_o | output | 1 | Single-cycle pulse when the wait expires |
| limit_o | output | LIM_W | Currently armed limit in carrier cycles |
| wtxm_err_o | output | 1 | Single-cycle pulse for a reserved multiplier |

## Verification
The bench builds the block with BASE_SHIFT=1, MAX_EXP=6 and ACT_EXP=2, so limits range from 2 to 128 cycles and the activation limit is 8. With limits this short, every exponent code from 0 to 7 can be timed to the exact cycle, and so can the full 64-value multiplier range at each legal exponent. The saturation corner is hit many times, because products up to 59 × 128 are capped at 128. The runs also cover cancellation on the final edge, restart during a wait, the extension surviving timeouts, and reserved codes arriving over a live extension.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
  typedef enum logic {
    CNT_IDLE,
    CNT_RUN
  } cnt_state_e;

  function automatic int lim_width(input int base_shift, input int max_exp);
    return base_shift + max_exp + 1;
  endfunction
endpackage

// File: rtl/fwt_limit_calc.sv
module fwt_limit_calc #(
  parameter int BASE_SHIFT = 12,
  parameter int MAX_EXP    = 14,
  parameter int ACT_EXP    = 4,
  parameter int FWI_W      = 4,
  parameter int WTXM_W     = 6,
  parameter int LIM_W      = fwt_pkg::lim_width(BASE_SHIFT, MAX_EXP)
) (
  input  logic [FWI_W-1:0]  fwi_i,
  input  logic              act_mode_i,
  input  logic              ext_on_i,
  input  logic [WTXM_W-1:0] ext_mult_i,
  output logic [LIM_W-1:0]  lim_o
);
  localparam int PROD_W = LIM_W + WTXM_W;
  localparam logic [LIM_W-1:0] MAX_LIM = LIM_W'(1) << (BASE_SHIFT + MAX_EXP);

  logic [LIM_W-1:0]  act_lim;
  logic [FWI_W-1:0]  fwi_eff;
  logic [LIM_W-1:0]  base_lim;
  logic [PROD_W-1:0] prod;
  logic [LIM_W-1:0]  ext_lim;

  // activation limit cannot exceed the absolute maximum
  generate
    if (ACT_EXP >= MAX_EXP) begin : g_act_cap
      assign act_lim = MAX_LIM;
    end else begin : g_act_fix
      assign act_lim = LIM_W'(1) << (BASE_SHIFT + ACT_EXP);
    end
  endgenerate

  always_comb begin
    fwi_eff  = (fwi_i > FWI_W'(MAX_EXP)) ? FWI_W'(MAX_EXP) : fwi_i;
    base_lim = MAX_LIM >> (FWI_W'(MAX_EXP) - fwi_eff);
    prod     = PROD_W'(base_lim) * PROD_W'(ext_mult_i);
    ext_lim  = (prod > PROD_W'(MAX_LIM)) ? MAX_LIM : prod[LIM_W-1:0];
    if (act_mode_i)    lim_o = act_lim;
    else if (ext_on_i) lim_o = ext_lim;
    else               lim_o = base_lim;
  end
endmodule

// File: rtl/fwt_ext_hold.sv
module fwt_ext_hold #(
  parameter int WTXM_W   = 6,
  parameter int WTXM_MIN = 1,
  parameter int WTXM_MAX = 59
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WTXM_W-1:0] mult_i,
  input  logic              clear_i,
  output logic              ext_on_o,
  output logic [WTXM_W-1:0] mult_o,
  output logic              err_o
);
  logic reserved;
  assign reserved = (mult_i < WTXM_W'(WTXM_MIN)) || (mult_i > WTXM_W'(WTXM_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_on_o <= 1'b0;
      mult_o   <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= load_i && reserved;
      // a legal load wins over a same-cycle clear
      if (load_i && !reserved) begin
        ext_on_o <= 1'b1;
        mult_o   <= mult_i;
      end else if (clear_i) begin
        ext_on_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fwt_wait_cnt.sv
module fwt_wait_cnt #(
  parameter int               LIM_W     = 27,
  parameter logic [LIM_W-1:0] RESET_LIM = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             timeout_o,
  output logic [LIM_W-1:0] armed_o
);
  import fwt_pkg::*;

  cnt_state_e       state_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt_q + LIM_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= CNT_IDLE;
      cnt_q     <= '0;
      armed_o   <= RESET_LIM;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (start_i) begin
        state_q <= CNT_RUN;
        cnt_q   <= '0;
        armed_o <= lim_i;
      end else if (state_q == CNT_RUN) begin
        if (stop_i) begin
          state_q <= CNT_IDLE;
        end else if (cnt_nxt == armed_o) begin
          timeout_o <= 1'b1;
          state_q   <= CNT_IDLE;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/fwt_supervisor.sv
module fwt_supervisor #(
  parameter int BASE_SHIFT = 12,
  parameter int MAX_EXP    = 14,
  parameter int ACT_EXP    = 4,
  parameter int FWI_W      = 4,
  parameter int WTXM_W     = 6,
  parameter int WTXM_MIN   = 1,
  parameter int WTXM_MAX   = 59,
  parameter int LIM_W      = fwt_pkg::lim_width(BASE_SHIFT, MAX_EXP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FWI_W-1:0]  fwi_i,
  input  logic              act_mode_i,
  input  logic              tx_end_i,
  input  logic              rx_start_i,
  input  logic              wtx_load_i,
  input  logic [WTXM_W-1:0] wtxm_i,
  output logic              timeout_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic              wtxm_err_o
);
  localparam int ACT_EFF = (ACT_EXP < MAX_EXP) ? ACT_EXP : MAX_EXP;
  localparam logic [LIM_W-1:0] RESET_LIM = LIM_W'(1) << (BASE_SHIFT + ACT_EFF);

  logic              ext_on;
  logic [WTXM_W-1:0] ext_mult;
  logic [LIM_W-1:0]  sel_lim;

  fwt_ext_hold #(
    .WTXM_W  (WTXM_W),
    .WTXM_MIN(WTXM_MIN),
    .WTXM_MAX(WTXM_MAX)
  ) u_ext (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (wtx_load_i),
    .mult_i  (wtxm_i),
    .clear_i (rx_start_i),
    .ext_on_o(ext_on),
    .mult_o  (ext_mult),
    .err_o   (wtxm_err_o)
  );

  fwt_limit_calc #(
    .BASE_SHIFT(BASE_SHIFT),
    .MAX_EXP   (MAX_EXP),
    .ACT_EXP   (ACT_EXP),
    .FWI_W     (FWI_W),
    .WTXM_W    (WTXM_W),
    .LIM_W     (LIM_W)
  ) u_calc (
    .fwi_i     (fwi_i),
    .act_mode_i(act_mode_i),
    .ext_on_i  (ext_on),
    .ext_mult_i(ext_mult),
    .lim_o     (sel_lim)
  );

  fwt_wait_cnt #(
    .LIM_W    (LIM_W),
    .RESET_LIM(RESET_LIM)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (tx_end_i),
    .stop_i   (rx_start_i),
    .lim_i    (sel_lim),
    .timeout_o(timeout_o),
    .armed_o  (limit_o)
  );
endmodule

// File: rtl/fwt_supervisor_chk.sv
module fwt_supervisor_chk #(
  parameter int BASE_SHIFT = 12,
  parameter int MAX_EXP    = 14,
  parameter int ACT_EXP    = 4,
  parameter int FWI_W      = 4,
  parameter int WTXM_W     = 6,
  parameter int WTXM_MIN   = 1,
  parameter int WTXM_MAX   = 59,
  parameter int LIM_W      = 27
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FWI_W-1:0]  fwi_i,
  input logic              act_mode_i,
  input logic              tx_end_i,
  input logic              rx_start_i,
  input logic              wtx_load_i,
  input logic [WTXM_W-1:0] wtxm_i,
  input logic              timeout_o,
  input logic [LIM_W-1:0]  limit_o,
  input logic              wtxm_err_o
);
  localparam int ACT_EFF = (ACT_EXP < MAX_EXP) ? ACT_EXP : MAX_EXP;
  localparam logic [LIM_W-1:0] MAX_LIM = LIM_W'(1) << (BASE_SHIFT + MAX_EXP);
  localparam logic [LIM_W-1:0] ACT_LIM = LIM_W'(1) << (BASE_SHIFT + ACT_EFF);

  logic rsv;
  assign rsv = (wtxm_i < WTXM_W'(WTXM_MIN)) || (wtxm_i > WTXM_W'(WTXM_MAX));

  // R1
  limit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_end_i |=> $stable(limit_o));
  // R5
  limit_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_i |=> (limit_o <= MAX_LIM) && (limit_o != '0));
  // R2
  act_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_i && act_mode_i |=> limit_o == ACT_LIM);
  // R3
  timeout_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
  // R4
  rx_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_start_i |=> !timeout_o);
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_i |=> !timeout_o);
  // R7
  rsv_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wtx_load_i && rsv |=> wtxm_err_o);
  // R7
  legal_noflag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wtx_load_i && rsv) |=> !wtxm_err_o);

  logic unused_ok;
  assign unused_ok = ^fwi_i;
endmodule

bind fwt_supervisor fwt_supervisor_chk #(
  .BASE_SHIFT(BASE_SHIFT),
  .MAX_EXP   (MAX_EXP),
  .ACT_EXP   (ACT_EXP),
  .FWI_W     (FWI_W),
  .WTXM_W    (WTXM_W),
  .WTXM_MIN  (WTXM_MIN),
  .WTXM_MAX  (WTXM_MAX),
  .LIM_W     (LIM_W)
) u_chk (.*);

// File: tb/fwt_supervisor_bench.sv
module fwt_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BS = 1;
  localparam int MX = 6;
  localparam int AE = 2;
  localparam int LW = BS + MX + 1;
  localparam int MAXL = 1 << (BS + MX);
  localparam int ACTL = 1 << (BS + AE);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    fwi = '0;
  logic          act = 1'b0;
  logic          tx = 1'b0;
  logic          rx = 1'b0;
  logic          ld = 1'b0;
  logic [5:0]    m = '0;
  logic          to;
  logic [LW-1:0] lim;
  logic          err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwt_supervisor #(.BASE_SHIFT(BS), .MAX_EXP(MX), .ACT_EXP(AE)) u_fwt_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .fwi_i(fwi), .act_mode_i(act),
    .tx_end_i(tx), .rx_start_i(rx), .wtx_load_i(ld), .wtxm_i(m),
    .timeout_o(to), .limit_o(lim), .wtxm_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic int base_of(input int f);
    return (1 << BS) << ((f > MX) ? MX : f);
  endfunction

  function automatic int ext_of(input int f, input int mm);
    int p;
    p = base_of(f) * mm;
    return (p > MAXL) ? MAXL : p;
  endfunction

  // ends at the negedge after the sampling edge E0
  task automatic arm(input int exp_l, input string req);
    @(negedge clk) tx = 1'b1;
    @(negedge clk) tx = 1'b0;
    chk(int'(lim) == exp_l, req, int'(lim), exp_l);
  endtask

  task automatic measure(input int exp_l, input string req);
    int n;
    n = 0;
    while (!to && n < MAXL + 8) begin
      @(negedge clk);
      n++;
    end
    chk(n == exp_l, req, n, exp_l);
    @(negedge clk);
    chk(!to, "R3 pulse width", int'(to), 0);
  endtask

  task automatic load(input int mm, input bit exp_err);
    @(negedge clk) begin ld = 1'b1; m = 6'(mm); end
    @(negedge clk) ld = 1'b0;
    chk(err == exp_err, "R7 flag", int'(err), int'(exp_err));
  endtask

  task automatic rx_pulse();
    @(negedge clk) rx = 1'b1;
    @(negedge clk) rx = 1'b0;
  endtask

  task automatic no_timeout(input int span, input string req);
    int seen;
    seen = 0;
    repeat (span) begin
      @(negedge clk);
      if (to) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 200000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(!to, "R9 timeout", int'(to), 0);
    chk(!err, "R9 err", int'(err), 0);
    chk(int'(lim) == ACTL, "R9 limit", int'(lim), ACTL);
    no_timeout(MAXL + 4, "R9 idle");

    // R1 exponent sweep including clamped codes
    for (int f = 0; f < 16; f++) begin
      fwi = 4'(f);
      arm(base_of(f), "R1 limit");
      measure(base_of(f), "R1/R3 timing");
    end

    // R5 R7 multiplier sweep at every legal exponent
    for (int f = 0; f <= MX; f++) begin
      fwi = 4'(f);
      for (int mm = 0; mm < 64; mm++) begin
        bit ok;
        ok = (mm >= 1) && (mm <= 59);
        load(mm, !ok);
        arm(ok ? ext_of(f, mm) : base_of(f), "R5 extended limit");
        measure(ok ? ext_of(f, mm) : base_of(f), "R5 extended timing");
        rx_pulse();
      end
    end

    // R7 reserved code over a live extension keeps it
    fwi = 4'd2;
    load(3, 1'b0);
    load(62, 1'b1);
    load(0, 1'b1);
    arm(ext_of(2, 3), "R7 extension kept");
    measure(ext_of(2, 3), "R7 timing");
    // R6 extension survives a timeout
    arm(ext_of(2, 3), "R6 after timeout");
    measure(ext_of(2, 3), "R6 timing");
    // R2 activation overrides but keeps extension
    act = 1'b1;
    arm(ACTL, "R2 limit");
    measure(ACTL, "R2 timing");
    act = 1'b0;
    arm(ext_of(2, 3), "R2 extension held");
    // R6 cancel by reply clears extension
    repeat (3) @(negedge clk);
    rx = 1'b1;
    @(negedge clk) rx = 1'b0;
    no_timeout(MAXL, "R6 reply cancels");
    arm(base_of(2), "R6 back to base");
    measure(base_of(2), "R6 base timing");

    // R4 cancel on the final edge
    fwi = 4'd3;
    arm(base_of(3), "R4 limit");
    repeat (base_of(3) - 1) @(negedge clk);
    rx = 1'b1;
    @(negedge clk) rx = 1'b0;
    chk(!to, "R4 last edge", int'(to), 0);
    no_timeout(MAXL, "R4 no late timeout");

    // R8 restart during a wait with a new exponent
    arm(base_of(3), "R8 first");
    repeat (5) @(negedge clk);
    fwi = 4'd1;
    arm(base_of(1), "R8 rearm limit");
    measure(base_of(1), "R8 restart timing");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule